// File: doc/BRIEF.md
# Serial EEPROM I2C Target Address Front End

This block is the receive side of an I2C target that behaves like a small serial EEPROM. A fast system clock oversamples the SCL and SDA lines. The block finds START and STOP conditions and shifts in the first byte of each transfer. It answers only when that byte carries the fixed device-type code and the three chip-select bits that match the external strap pins. When the byte matches, the block pulls SDA low for the acknowledge clock and reports whether the transfer is a read or a write.

After a write request, the block takes in two more bytes that form the word address. It acknowledges each one and builds a 15-bit pointer from them. A downstream memory controller uses the pointer, the operation type, a transaction-active flag and a one-cycle load strobe. Storing data, buffering pages, timing the write cycle and shifting out read data are all left to that controller.

Top module: `eeprom_addr_front`

## Requirements
- R1: Synchronous active-high reset clears `sda_pull_o`, `active_o`, `op_read_o`, `addr_load_o` and `addr_o`. The bus is left released.
- R2: The first byte after a START is a control byte, received MSB first. The block answers only if bits 7..4 equal 4'b1010 and bits 3..1 equal `sel_pins[2:0]` in that order. On a match it sets `active_o`. On a mismatch it never pulls SDA and ignores all traffic until the next START or STOP.
- R3: On a matching control byte, `op_read_o` takes its bit 0: 1 selects a read and 0 selects a write.
- R4: The acknowledge is a pull-low enable only. It rises on the first SCL falling edge after the eighth data bit and falls on the SCL falling edge that ends the ninth clock. SDA therefore stays stable through the whole high phase of the acknowledge clock.
- R5: After a write control byte, exactly two further bytes are acknowledged. After a read control byte, no later byte of that transfer is acknowledged.
- R6: `addr_o[14:8]` takes bits 6..0 of the first address byte, and bit 7 of that byte is discarded. `addr_o[7:0]` takes the second address byte. The chip-select bits never enter the pointer. Each half is written when its byte completes.
- R7: `addr_load_o` is high for exactly one clock, in the cycle after the eighth bit of the second address byte is taken. `addr_o` already holds the full pointer in that cycle.
- R8: A START seen at any point, including in the middle of a byte, clears `active_o` and the acknowledge and restarts control-byte reception.
- R9: A STOP clears `active_o` and the acknowledge, and returns the block to idle.
- R10: SCL and SDA pass through a two-flop synchronizer. Each output reacts in the third clock after the line change that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| sel_pins | input | 3 | Chip-select strap levels, bit 2 first on the bus |
| sda_pull_o | output | 1 | Open-drain pull-low enable for SDA |
| active_o | output | 1 | Transfer addressed to this device is in progress |
| op_read_o | output | 1 | Operation of the last matched control byte, 1 = read |
| addr_o | output | 15 | Word address pointer |
| addr_load_o | output | 1 | One-cycle strobe when a full pointer has been loaded |

## Verification
A bit counter that is off by one shows up at once as an acknowledge on the wrong SCL clock: the pull-low enable rises one bus bit early or late. A wrong state after a mismatch or a read shows up as a stray acknowledge on the next byte. A failure to clear on START or STOP shows up as `active_o` still high three clocks after that line event. The bench predicts every output on every system clock, so any of these faults is reported in the first cycle in which it reaches a port.

// File: rtl/eeprom_fe_pkg.sv
package eeprom_fe_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CTRL,
    ST_AHI,
    ST_ALO
  } fe_state_t;
endpackage

// File: rtl/i2c_line_sampler.sv
module i2c_line_sampler #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int TOP = STAGES - 1;

  logic [TOP:0] scl_q, sda_q;
  logic         scl_p, sda_p;
  logic         scl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[TOP-1:0], scl_i};
      sda_q <= {sda_q[TOP-1:0], sda_i};
      scl_p <= scl_q[TOP];
      sda_p <= sda_q[TOP];
    end
  end

  assign scl_s     = scl_q[TOP];
  assign sda_s     = sda_q[TOP];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/eeprom_addr_fsm.sv
module eeprom_addr_fsm
  import eeprom_fe_pkg::*;
#(
  parameter int              ADDR_W    = 15,
  parameter int              SEL_W     = 3,
  parameter logic [6-SEL_W:0] TYPE_CODE = 4'b1010
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [SEL_W-1:0]  sel_pins,
  output logic              sda_pull_o,
  output logic              active_o,
  output logic              op_read_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              addr_load_o
);
  localparam int CODE_W = BYTE_W - 1 - SEL_W;
  localparam int HI_W   = ADDR_W - BYTE_W;

  fe_state_t         state, resume;
  logic [3:0]        bit_cnt;
  logic [BYTE_W-2:0] shreg;
  logic              ack_pend, ack_phase;
  logic [BYTE_W-1:0] byte_w;
  logic              shift_en, byte_done, ctrl_match;

  assign byte_w     = {shreg, sda_s};
  assign shift_en   = scl_rise && !ack_pend && !ack_phase &&
                      (state != ST_IDLE) && (bit_cnt < 4'd8);
  assign byte_done  = shift_en && (bit_cnt == 4'd7);
  assign ctrl_match = (byte_w[BYTE_W-1 -: CODE_W] == TYPE_CODE) &&
                      (byte_w[SEL_W:1] == sel_pins);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      resume      <= ST_IDLE;
      bit_cnt     <= '0;
      shreg       <= '0;
      ack_pend    <= 1'b0;
      ack_phase   <= 1'b0;
      sda_pull_o  <= 1'b0;
      active_o    <= 1'b0;
      op_read_o   <= 1'b0;
      addr_o      <= '0;
      addr_load_o <= 1'b0;
    end else if (start_det || stop_det) begin
      state       <= start_det ? ST_CTRL : ST_IDLE;
      bit_cnt     <= '0;
      ack_pend    <= 1'b0;
      ack_phase   <= 1'b0;
      sda_pull_o  <= 1'b0;
      active_o    <= 1'b0;
      addr_load_o <= 1'b0;
    end else begin
      addr_load_o <= 1'b0;
      if (shift_en) begin
        shreg   <= byte_w[BYTE_W-2:0];
        bit_cnt <= bit_cnt + 4'd1;
      end
      if (byte_done) begin
        case (state)
          ST_CTRL: begin
            if (ctrl_match) begin
              active_o  <= 1'b1;
              op_read_o <= byte_w[0];
              ack_pend  <= 1'b1;
              resume    <= byte_w[0] ? ST_IDLE : ST_AHI;
            end else begin
              state <= ST_IDLE;
            end
          end
          ST_AHI: begin
            addr_o[ADDR_W-1:BYTE_W] <= byte_w[HI_W-1:0];
            ack_pend <= 1'b1;
            resume   <= ST_ALO;
          end
          ST_ALO: begin
            addr_o[BYTE_W-1:0] <= byte_w;
            addr_load_o <= 1'b1;
            ack_pend    <= 1'b1;
            resume      <= ST_IDLE;
          end
          default: ;
        endcase
      end
      if (scl_fall) begin
        if (ack_pend) begin
          sda_pull_o <= 1'b1;
          ack_phase  <= 1'b1;
          ack_pend   <= 1'b0;
        end else if (ack_phase) begin
          sda_pull_o <= 1'b0;
          ack_phase  <= 1'b0;
          bit_cnt    <= '0;
          state      <= resume;
        end
      end
    end
  end
endmodule

// File: rtl/eeprom_addr_front.sv
module eeprom_addr_front #(
  parameter int               ADDR_W      = 15,
  parameter int               SEL_W       = 3,
  parameter int               SYNC_STAGES = 2,
  parameter logic [6-SEL_W:0] TYPE_CODE   = 4'b1010
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [SEL_W-1:0]  sel_pins,
  output logic              sda_pull_o,
  output logic              active_o,
  output logic              op_read_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              addr_load_o
);
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2c_line_sampler #(.STAGES(SYNC_STAGES)) sampler_i (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  eeprom_addr_fsm #(
    .ADDR_W    (ADDR_W),
    .SEL_W     (SEL_W),
    .TYPE_CODE (TYPE_CODE)
  ) fsm_i (
    .clk         (clk),
    .rst         (rst),
    .sda_s       (sda_s),
    .scl_rise    (scl_rise),
    .scl_fall    (scl_fall),
    .start_det   (start_det),
    .stop_det    (stop_det),
    .sel_pins    (sel_pins),
    .sda_pull_o  (sda_pull_o),
    .active_o    (active_o),
    .op_read_o   (op_read_o),
    .addr_o      (addr_o),
    .addr_load_o (addr_load_o)
  );
endmodule

// File: rtl/eeprom_addr_front_chk.sv
module eeprom_addr_front_chk (
  input logic clk,
  input logic rst,
  input logic scl_fall,
  input logic start_det,
  input logic stop_det,
  input logic sda_pull_o,
  input logic active_o,
  input logic op_read_o,
  input logic addr_load_o
);
  // R2: the bus is only pulled for a device that was addressed
  a_r2_pull_needs_match: assert property (@(posedge clk) disable iff (rst)
    sda_pull_o |-> active_o);

  // R4: the acknowledge starts right after a detected SCL fall
  a_r4_ack_after_fall: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pull_o) |-> $past(scl_fall));

  // R4: the acknowledge ends on an SCL fall unless a START or STOP cut it short
  a_r4_release_on_fall: assert property (@(posedge clk) disable iff (rst)
    ($fell(sda_pull_o) && !$past(start_det) && !$past(stop_det)) |-> $past(scl_fall));

  // R7: the load strobe lasts one cycle
  a_r7_load_single: assert property (@(posedge clk) disable iff (rst)
    addr_load_o |=> !addr_load_o);

  // R7: a pointer load only happens inside an addressed write
  a_r7_load_in_write: assert property (@(posedge clk) disable iff (rst)
    addr_load_o |-> (active_o && !op_read_o));

  // R8: START drops the transfer and the acknowledge
  a_r8_start_clears: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (!active_o && !sda_pull_o));

  // R9: STOP drops the transfer and the acknowledge
  a_r9_stop_clears: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (!active_o && !sda_pull_o));
endmodule

bind eeprom_addr_front eeprom_addr_front_chk chk_i (
  .clk         (clk),
  .rst         (rst),
  .scl_fall    (scl_fall),
  .start_det   (start_det),
  .stop_det    (stop_det),
  .sda_pull_o  (sda_pull_o),
  .active_o    (active_o),
  .op_read_o   (op_read_o),
  .addr_load_o (addr_load_o)
);

// File: tb/eeprom_addr_front_tb.sv
`timescale 1ns/1ps
module eeprom_addr_front_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic [2:0]  sel = 3'b101;
  logic        sda_line;
  logic        sda_pull_o, active_o, op_read_o, addr_load_o;
  logic [14:0] addr_o;

  int checks = 0;
  int errors = 0;
  int n_ack  = 0;
  int n_load = 0;
  bit done   = 0;
  logic prev_pull = 1'b0;

  always #2.5 clk = ~clk;

  assign sda_line = sda_m & ~sda_pull_o;

  eeprom_addr_front dut_i (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sel_pins(sel),
    .sda_pull_o(sda_pull_o), .active_o(active_o), .op_read_o(op_read_o),
    .addr_o(addr_o), .addr_load_o(addr_load_o)
  );

  // Behavioural reference: line history delayed by the synchronizer (R10)
  bit hs[$] = '{1, 1, 1, 1};
  bit hd[$] = '{1, 1, 1, 1};
  int   m_state = 0;   // 0 idle, 1 control, 2 addr high, 3 addr low
  int   m_resume = 0;
  int   m_cnt = 0;
  int   m_sh = 0;
  bit   m_pend = 0, m_ackph = 0;
  bit   e_pull = 0, e_act = 0, e_rd = 0, e_load = 0;
  int   e_addr = 0;

  always @(posedge clk) begin
    logic [7:0] mb;
    bit c_scl, p_scl, c_sda, p_sda;
    hs.push_back(scl_m);
    hd.push_back(sda_line);
    if (hs.size() > 4) begin
      void'(hs.pop_front());
      void'(hd.pop_front());
    end
    c_scl = hs[1]; p_scl = hs[0]; c_sda = hd[1]; p_sda = hd[0];
    if (rst) begin
      m_state = 0; m_cnt = 0; m_sh = 0; m_pend = 0; m_ackph = 0; m_resume = 0;
      e_pull = 0; e_act = 0; e_rd = 0; e_load = 0; e_addr = 0;
    end else if ((p_scl && c_scl && p_sda && !c_sda) || (p_scl && c_scl && !p_sda && c_sda)) begin
      m_state = (p_sda && !c_sda) ? 1 : 0;
      m_cnt = 0; m_pend = 0; m_ackph = 0;
      e_pull = 0; e_act = 0; e_load = 0;
    end else begin
      e_load = 0;
      if (c_scl && !p_scl && m_state != 0 && !m_pend && !m_ackph && m_cnt < 8) begin
        m_sh = ((m_sh << 1) | c_sda) & 8'hFF;
        m_cnt++;
        if (m_cnt == 8) begin
          mb = m_sh[7:0];
          if (m_state == 1) begin
            if (mb[7:4] == 4'b1010 && mb[3:1] == sel) begin
              e_act = 1; e_rd = mb[0]; m_pend = 1; m_resume = mb[0] ? 0 : 2;
            end else m_state = 0;
          end else if (m_state == 2) begin
            e_addr = (e_addr & 8'hFF) | (int'(mb[6:0]) << 8); m_pend = 1; m_resume = 3;
          end else if (m_state == 3) begin
            e_addr = (e_addr & 16'h7F00) | int'(mb); e_load = 1; m_pend = 1; m_resume = 0;
          end
        end
      end else if (!c_scl && p_scl) begin
        if (m_pend) begin e_pull = 1; m_ackph = 1; m_pend = 0; end
        else if (m_ackph) begin e_pull = 0; m_ackph = 0; m_cnt = 0; m_state = m_resume; end
      end
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-clock comparison against the reference, plus event counters
  always @(negedge clk) begin
    if (!rst) begin
      check("R4 sda_pull_o", sda_pull_o, e_pull);
      check("R2 active_o", active_o, e_act);
      check("R3 op_read_o", op_read_o, e_rd);
      check("R6 addr_o", addr_o, e_addr);
      check("R7 addr_load_o", addr_load_o, e_load);
      if (sda_pull_o && !prev_pull) n_ack++;
      if (addr_load_o) n_load++;
    end
    prev_pull = sda_pull_o;
  end

  task automatic waitc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; waitc(4); scl_m = 1'b1; waitc(8);
    sda_m = 1'b0; waitc(8); scl_m = 1'b0; waitc(4);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; waitc(4); scl_m = 1'b1; waitc(8); sda_m = 1'b1; waitc(8);
  endtask

  task automatic bus_bit(bit b);
    sda_m = b; waitc(8); scl_m = 1'b1; waitc(16); scl_m = 1'b0; waitc(8);
  endtask

  task automatic bus_byte(logic [7:0] b);
    for (int i = 7; i >= 0; i--) bus_bit(b[i]);
    bus_bit(1'b1);
  endtask

  initial begin
    waitc(5);
    rst = 1'b0;
    waitc(2);
    // R1: reset state
    check("R1 pull after reset", sda_pull_o, 0);
    check("R1 active after reset", active_o, 0);
    check("R1 addr after reset", addr_o, 0);

    // R5 R6 R7: write with high-byte MSB set (discarded)
    n_ack = 0; n_load = 0;
    bus_start(); bus_byte(8'hAA); bus_byte(8'hD5); bus_byte(8'h3C);
    waitc(4);
    check("R5 write acks", n_ack, 3);
    check("R6 pointer MSB dropped", addr_o, 15'h553C);
    check("R7 one load strobe", n_load, 1);
    check("R3 write op", op_read_o, 0);
    bus_stop(); waitc(4);
    check("R9 stop clears active", active_o, 0);

    // R3 R5: read control, later byte not acknowledged
    n_ack = 0;
    bus_start(); bus_byte(8'hAB);
    check("R3 read op", op_read_o, 1);
    check("R2 active on read", active_o, 1);
    bus_byte(8'h12);
    check("R5 read takes no address", n_ack, 1);
    check("R6 pointer kept on read", addr_o, 15'h553C);
    bus_stop(); waitc(4);

    // R2: wrong type code, then a valid-looking byte is ignored
    n_ack = 0;
    bus_start(); bus_byte(8'h9A); bus_byte(8'hAA);
    check("R2 no ack on bad code", n_ack, 0);
    check("R2 inactive on bad code", active_o, 0);
    bus_stop(); waitc(4);

    // R2: wrong chip select
    n_ack = 0;
    bus_start(); bus_byte(8'hA8);
    check("R2 no ack on bad select", n_ack, 0);
    bus_stop(); waitc(4);

    // R8: repeated START inside the low address byte
    n_ack = 0;
    bus_start(); bus_byte(8'hAA); bus_byte(8'h01);
    bus_bit(1); bus_bit(0); bus_bit(1);
    bus_start(); waitc(4);
    check("R8 start clears active", active_o, 0);
    check("R6 partial pointer", addr_o, 15'h013C);
    bus_byte(8'hAB);
    check("R8 new control accepted", active_o, 1);
    check("R8 acks across restart", n_ack, 3);
    bus_stop(); waitc(4);

    // R6: all-ones and MSB-only address values
    bus_start(); bus_byte(8'hAA); bus_byte(8'h7F); bus_byte(8'hFF);
    check("R6 full pointer", addr_o, 15'h7FFF);
    bus_start(); bus_byte(8'hAA); bus_byte(8'h80); bus_byte(8'h00);
    check("R6 MSB only gives zero", addr_o, 15'h0000);
    bus_stop(); waitc(4);

    // R2: other strap setting
    sel = 3'b000; n_ack = 0;
    waitc(4);
    bus_start(); bus_byte(8'hA0);
    check("R2 ack with straps 000", n_ack, 1);
    bus_stop(); waitc(8);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R5 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule